// File: doc/BRIEF.md
# Operand Bypass and Load-Delay Control for a Five-Stage Pipeline

This block decides, for the instruction currently in the decode stage of a five-stage pipeline (fetch, decode, execute, buffer/data, write-back), where each of its three source operands should come from. Each source register number is compared against the destination held by the execute, buffer/data and write-back result registers. A per-operand 2-bit select tells the operand multiplexers to take the register file value or one of the three in-flight results. When the newest producer is a memory load still in execute, its data does not exist yet. The block then raises a stall, and a bubble marker follows in the next cycle.

Reads of the program counter register (index 15 with the default parameters) never take a bypass. The r15 operand is the fetch stage's incremented PC, taken straight from the fetch stage without going through the fetch/decode register. That value equals the decoding instruction's own address plus 8. The datapath, the multiplexers and the pipeline registers all sit outside this block.

Top module: `pipe_bypass_ctl`

## Requirements
- R1: Select encoding per operand is 0 = register file, 1 = execute output, 2 = buffer/data output, 3 = write-back. A used source whose number equals the execute destination gets select 1 in the same cycle, provided execute has write-enable set and is not a load.
- R2: A used source that matches only the buffer/data destination (write-enable set) gets select 2. One that matches only the write-back destination (write-enable set) gets select 3.
- R3: When several stages hold a matching destination with write-enable set, the youngest wins: execute over buffer/data over write-back.
- R4: A stage whose write-enable is clear is never chosen, even when its destination number matches.
- R5: A source equal to the top register index (the PC, 15) always gets select 0 and never causes a stall.
- R6: Stall is high in the same cycle when a used source matches the execute destination while execute holds a load with write-enable set. The select for that operand is then 0. A load whose destination matches no used source causes no stall.
- R7: A source whose used flag is clear gets select 0 and causes no stall.
- R8: Bubble is a registered flag. It is low after reset and is high in exactly the cycles that follow a cycle with stall high.
- R9: The r15 operand output equals the fetch-stage PC+4 input in the same cycle.
- R10: Once a load has moved on into buffer/data, a dependent operand gets select 2 with no stall.
- R11: The three operands are resolved independently. Each can take a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_idx | input | 12 | Three 4-bit source register numbers, operand i at [4i+3:4i] |
| src_used | input | 3 | Operand i is really read by the decode instruction |
| ex_dst | input | 4 | Destination number in execute |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| bd_dst | input | 4 | Destination number in buffer/data |
| bd_we | input | 1 | Buffer/data instruction writes a register |
| wb_dst | input | 4 | Destination number in write-back |
| wb_we | input | 1 | Write-back instruction writes a register |
| pc4_fetch | input | 32 | Incremented PC from fetch |
| fwd_sel | output | 6 | Three 2-bit operand selects, operand i at [2i+1:2i] |
| stall | output | 1 | Hold PC and fetch/decode register this cycle |
| bubble | output | 1 | Execute holds an injected empty slot |
| r15_value | output | 32 | Value returned for PC reads in decode |

## Verification
The selects, the stall and the r15 value are combinational and settle in the same cycle as the inputs that cause them. The bench therefore drives inputs shortly after a rising edge and samples them a few time units later, well before the next edge. Bubble passes through one register, so it is checked right after the edge that follows the stalling cycle. It is checked again one cycle later to confirm it drops. The load-use sequence repeats this over consecutive cycles, with the load first in execute and then in buffer/data.

// File: rtl/pipe_bypass_pkg.sv
package pipe_bypass_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_EX  = 2'd1,
        SRC_BD  = 2'd2,
        SRC_WB  = 2'd3
    } fwd_src_e;

    typedef struct packed {
        logic bubble;
    } ctl_state_t;
endpackage

// File: rtl/operand_pick.sv
module operand_pick
    import pipe_bypass_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic [REG_W-1:0] src,
    input  logic             used,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_we,
    input  logic             ex_load,
    input  logic [REG_W-1:0] bd_dst,
    input  logic             bd_we,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_we,
    output logic [1:0]       sel,
    output logic             hold
);
    localparam logic [REG_W-1:0] PC_IDX = {REG_W{1'b1}};

    logic     live;
    logic     hit_ex, hit_bd, hit_wb;
    fwd_src_e pick;

    always_comb begin
        live   = used && (src != PC_IDX);
        hit_ex = live && ex_we && (ex_dst == src);
        hit_bd = live && bd_we && (bd_dst == src);
        hit_wb = live && wb_we && (wb_dst == src);
        hold   = hit_ex && ex_load;
        if (hit_ex)      pick = ex_load ? SRC_RF : SRC_EX;
        else if (hit_bd) pick = SRC_BD;
        else if (hit_wb) pick = SRC_WB;
        else             pick = SRC_RF;
        sel = pick;
    end

    // R4: a chosen stage must have its write-enable set
    always_comb begin
        if (sel == 2'd1) a_r4_ex_sel_we : assert (ex_we && !ex_load);
        if (sel == 2'd2) a_r4_bd_sel_we : assert (bd_we);
        if (sel == 2'd3) a_r4_wb_sel_we : assert (wb_we);
    end

    // R5: the PC index is never bypassed
    always_comb begin
        if (src == PC_IDX) a_r5_pc_not_fwd : assert (sel == 2'd0 && !hold);
    end
endmodule

// File: rtl/pipe_bypass_ctl.sv
module pipe_bypass_ctl
    import pipe_bypass_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int NSRC  = 3,
    parameter int XLEN  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC*REG_W-1:0]   src_idx,
    input  logic [NSRC-1:0]         src_used,
    input  logic [REG_W-1:0]        ex_dst,
    input  logic                    ex_we,
    input  logic                    ex_load,
    input  logic [REG_W-1:0]        bd_dst,
    input  logic                    bd_we,
    input  logic [REG_W-1:0]        wb_dst,
    input  logic                    wb_we,
    input  logic [XLEN-1:0]         pc4_fetch,
    output logic [2*NSRC-1:0]       fwd_sel,
    output logic                    stall,
    output logic                    bubble,
    output logic [XLEN-1:0]         r15_value
);
    localparam int SEL_W = 2;

    logic [NSRC-1:0] hold_vec;
    ctl_state_t      st_d, st_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_op
        operand_pick #(.REG_W(REG_W)) u_pick (
            .src     (src_idx[i*REG_W +: REG_W]),
            .used    (src_used[i]),
            .ex_dst  (ex_dst),
            .ex_we   (ex_we),
            .ex_load (ex_load),
            .bd_dst  (bd_dst),
            .bd_we   (bd_we),
            .wb_dst  (wb_dst),
            .wb_we   (wb_we),
            .sel     (fwd_sel[i*SEL_W +: SEL_W]),
            .hold    (hold_vec[i])
        );
    end

    always_comb begin
        stall       = |hold_vec;
        r15_value   = pc4_fetch;
        st_d        = st_q;
        st_d.bubble = stall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bubble = st_q.bubble;

    // R8: a stall is followed by a bubble on the next cycle
    a_r8_bubble_after_stall : assert property (
        @(posedge clk) disable iff (!rst_n) stall |=> bubble);
    // R8: no bubble without a preceding stall
    a_r8_no_stray_bubble : assert property (
        @(posedge clk) disable iff (!rst_n) !stall |=> !bubble);
    // R6: a stall needs a writing load in execute
    a_r6_stall_needs_load : assert property (
        @(posedge clk) disable iff (!rst_n) stall |-> (ex_load && ex_we));
    // R9: r15 operand tracks the fetch PC+4
    a_r9_pc_bypass : assert property (
        @(posedge clk) disable iff (!rst_n) r15_value == pc4_fetch);
endmodule

// File: tb/pipe_bypass_ctl_test.sv
module pipe_bypass_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_idx = '0;
    logic [2:0]  src_used = '0;
    logic [3:0]  ex_dst = '0, bd_dst = '0, wb_dst = '0;
    logic        ex_we = 1'b0, ex_load = 1'b0, bd_we = 1'b0, wb_we = 1'b0;
    logic [31:0] pc4_fetch = '0;
    logic [5:0]  fwd_sel;
    logic        stall, bubble;
    logic [31:0] r15_value;

    int total = 0;
    int bad = 0;
    bit timed_out = 0;

    pipe_bypass_ctl uut (
        .clk(clk), .rst_n(rst_n), .src_idx(src_idx), .src_used(src_used),
        .ex_dst(ex_dst), .ex_we(ex_we), .ex_load(ex_load),
        .bd_dst(bd_dst), .bd_we(bd_we), .wb_dst(wb_dst), .wb_we(wb_we),
        .pc4_fetch(pc4_fetch), .fwd_sel(fwd_sel), .stall(stall),
        .bubble(bubble), .r15_value(r15_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] sel_of(input int i);
        return fwd_sel[2*i +: 2];
    endfunction

    task automatic drive(input logic [3:0] s0, s1, s2, input logic [2:0] used,
                         input logic [3:0] exd, input logic exw, exl,
                         input logic [3:0] bdd, input logic bdw,
                         input logic [3:0] wbd, input logic wbw);
        @(posedge clk); #2;
        src_idx = {s2, s1, s0}; src_used = used;
        ex_dst = exd; ex_we = exw; ex_load = exl;
        bd_dst = bdd; bd_we = bdw; wb_dst = wbd; wb_we = wbw;
        #2;
    endtask

    task automatic t_reset;
        chk("R8 bubble low after reset", {31'd0, bubble}, 0);
        chk("R7 idle sel", {26'd0, fwd_sel}, 0);
        chk("R7 idle stall", {31'd0, stall}, 0);
    endtask

    task automatic t_single;
        drive(3, 5, 7, 3'b111, 3, 1, 0, 5, 1, 7, 1);
        chk("R1 ex fwd", sel_of(0), 1);
        chk("R2 bd fwd", sel_of(1), 2);
        chk("R2 wb fwd", sel_of(2), 3);
        chk("R11 no stall", {31'd0, stall}, 0);
    endtask

    task automatic t_priority;
        drive(4, 4, 4, 3'b111, 4, 1, 0, 4, 1, 4, 1);
        chk("R3 ex youngest", sel_of(0), 1);
        drive(4, 1, 1, 3'b001, 4, 0, 0, 4, 1, 4, 1);
        chk("R3 bd over wb", sel_of(0), 2);
        drive(4, 1, 1, 3'b001, 4, 0, 0, 4, 0, 4, 1);
        chk("R4 wb only", sel_of(0), 3);
        drive(4, 4, 4, 3'b111, 4, 0, 0, 4, 0, 4, 0);
        chk("R4 no we", {26'd0, fwd_sel}, 0);
    endtask

    task automatic t_pc;
        drive(15, 15, 2, 3'b011, 15, 1, 1, 15, 1, 15, 1);
        chk("R5 pc sel", {28'd0, sel_of(1), sel_of(0)}, 0);
        chk("R5 pc no stall", {31'd0, stall}, 0);
        pc4_fetch = 32'h0000_1008; #1;
        chk("R9 r15", r15_value, 32'h0000_1008);
        pc4_fetch = 32'hFFFF_FFFC; #1;
        chk("R9 r15 b", r15_value, 32'hFFFF_FFFC);
    endtask

    task automatic t_loaduse;
        drive(2, 6, 9, 3'b111, 6, 1, 1, 0, 0, 2, 1);
        chk("R6 stall", {31'd0, stall}, 1);
        chk("R6 stalled sel", sel_of(1), 0);
        chk("R11 other op", sel_of(0), 3);
        drive(2, 6, 9, 3'b111, 0, 0, 0, 6, 1, 2, 1);
        chk("R8 bubble", {31'd0, bubble}, 1);
        chk("R10 bd after load", sel_of(1), 2);
        chk("R10 no stall", {31'd0, stall}, 0);
        drive(2, 6, 9, 3'b111, 0, 0, 0, 0, 0, 6, 1);
        chk("R8 bubble drops", {31'd0, bubble}, 0);
    endtask

    task automatic t_unused;
        drive(1, 6, 2, 3'b101, 6, 1, 1, 6, 1, 0, 0);
        chk("R7 unused no stall", {31'd0, stall}, 0);
        chk("R7 unused sel", sel_of(1), 0);
        drive(1, 3, 2, 3'b111, 6, 1, 1, 0, 0, 0, 0);
        chk("R6 nonmatching load", {31'd0, stall}, 0);
        drive(1, 3, 2, 3'b111, 0, 0, 0, 0, 0, 0, 0);
        chk("R8 no bubble", {31'd0, bubble}, 0);
    endtask

    initial begin
        #(CLK_PERIOD*200);
        timed_out = 1;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #3;
        t_reset;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        t_single;
        t_priority;
        t_pc;
        t_loaduse;
        t_unused;
        if (!timed_out) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule